// File: doc/BRIEF.md
# Touch baseline calibration tracker

This block follows a calibrated baseline for each of several capacitive sense channels (three by default) and judges every new measurement as touched or untouched. Each measurement arrives as an 8-bit raw reading with a valid strobe. The low seven bits are turned into a working impedance by subtracting them from 127, and the baseline is stored in that same inverted form. Each channel has its own touch threshold. A shared drift band sets which small rises the baseline may follow; rises between the drift band and the touch threshold leave the baseline unchanged, and any reading below the baseline pulls it down at once.

Apart from this tracking on every sample, the block runs whole-array calibrations that load every baseline with the channel's latest working value. An automatic calibration fires once no channel has been touched for a programmable quiet period, counted in sensor-clock ticks. While the array stays untouched, it repeats at a programmable interval. A hold input stops the automatic scheme and lets the host request calibrations instead. One request kind always calibrates; the other waits until no channel is touched. Every calibration, of whatever origin, is announced by a one-cycle done pulse.

Top module: `touch_cal_tracker`

## Requirements
- R1: The working value of a channel is 127 minus bits [6:0] of its 8-bit raw reading, so bit 7 has no effect. The baselines use the same form. Channel i occupies raw bits [8i+7:8i], threshold bits [7i+6:7i] and baseline bits [7i+6:7i].
- R2: A sample whose working value is greater than baseline plus that channel's touch threshold drives the channel's touch output to 1 in the cycle after the strobe and leaves its baseline unchanged. Any other sample drives touch to 0.
- R3: A non-touch sample more than the drift band above the baseline leaves the baseline unchanged.
- R4: A sample above the baseline by at most the drift band moves the baseline by (this working value minus the previous working value of the channel). The result is limited to the range 0 to 127.
- R5: A sample below the baseline sets the baseline to that working value. A sample equal to the baseline leaves it unchanged.
- R6: With hold at 0, once no channel has been touched for quiet_cfg×64 ticks, the block calibrates every baseline to its latest working value. cal_done is high in the cycle after the tick that completes the count.
- R7: After an automatic calibration, further ones follow every repeat_cfg×50 ticks while no touch is present. Any touch output at 1 restarts the count from the full quiet period.
- R8: With hold at 1 no automatic calibration occurs. Host requests are accepted only while hold is 1, and lowering hold drops any pending request.
- R9: A force request raises force_pend in the next cycle. It calibrates in the cycle after that, whatever the touch state, and cal_done rises as force_pend falls.
- R10: A conditional request stays pending, with no calibration, while any touch output is 1. It calibrates in the first cycle with no touch present.
- R11: When a calibration falls in the same cycle as a valid sample, each baseline loads that sample's working value. The sample's touch verdict is still judged against the old baseline.
- R12: After reset every baseline is 127, every touch output is 0, and cal_done, force_pend and cond_pend are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle sensor-clock tick for the quiet and repeat counts |
| smp_valid | input | 1 | Raw sample strobe for all channels |
| smp_raw | input | 24 | Raw readings, 8 bits per channel |
| tvr_cfg | input | 21 | Touch thresholds, 7 bits per channel |
| evr_cfg | input | 7 | Drift band shared by all channels |
| quiet_cfg | input | 8 | Quiet period, in units of 64 ticks |
| repeat_cfg | input | 8 | Repeat interval, in units of 50 ticks |
| hold | input | 1 | 1 disables automatic calibration and enables host requests |
| force_req | input | 1 | Pulse: unconditional calibration request |
| cond_req | input | 1 | Pulse: calibration request gated by no touch |
| touch | output | 3 | Per-channel touch verdict |
| base_out | output | 21 | Per-channel baselines, 7 bits each |
| force_pend | output | 1 | Unconditional request waiting |
| cond_pend | output | 1 | Conditional request waiting |
| cal_done | output | 1 | One-cycle pulse after every calibration |

## Verification
A new sample's per-channel baseline update and a whole-array calibration can land in the same cycle. The bench provokes this by raising a force request under hold and then driving a sample in exactly the cycle where the request is pending. It expects each baseline to hold the new sample's working value, the touch verdicts to follow the baselines from before that cycle, and cal_done to rise together with the sample result. Automatic calibration and sample tracking are also interleaved, to show that a touch sample between ticks restarts the full quiet count rather than the shorter repeat count.

// File: rtl/touch_cal_pkg.sv
package touch_cal_pkg;
   typedef enum logic {
      PH_QUIET  = 1'b0,
      PH_REPEAT = 1'b1
   } cal_phase_e;
endpackage

// File: rtl/tcal_channel.sv
module tcal_channel #(
   parameter int RAW_W = 8,
   parameter int IMP_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [RAW_W-1:0] raw,
   input  logic [IMP_W-1:0] tvr,
   input  logic [IMP_W-1:0] evr,
   input  logic             cal_load,
   output logic             touch,
   output logic [IMP_W-1:0] base
);
   localparam int MAXV = (1 << IMP_W) - 1;
   localparam int EW   = IMP_W + 1;
   localparam int SW   = IMP_W + 2;

   logic [IMP_W-1:0] prev;
   logic [IMP_W-1:0] imp;
   logic [IMP_W-1:0] base_nxt;
   logic [IMP_W-1:0] drift_sat;
   logic [EW-1:0]    lim_touch, lim_band, imp_x;
   logic signed [SW-1:0] drift;
   logic             is_touch, in_freeze;

   if (RAW_W > IMP_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^raw[RAW_W-1:IMP_W];
   end

   assign imp       = IMP_W'(MAXV) - raw[IMP_W-1:0];
   assign imp_x     = {1'b0, imp};
   assign lim_touch = {1'b0, base} + {1'b0, tvr};
   assign lim_band  = {1'b0, base} + {1'b0, evr};
   assign is_touch  = imp_x > lim_touch;
   assign in_freeze = imp_x > lim_band;
   assign drift     = $signed({2'b00, base}) + $signed({2'b00, imp})
                    - $signed({2'b00, prev});

   always_comb begin
      if (drift[SW-1])                        drift_sat = '0;
      else if (drift[SW-2:0] > EW'(MAXV))     drift_sat = IMP_W'(MAXV);
      else                                    drift_sat = drift[IMP_W-1:0];
   end

   always_comb begin
      base_nxt = base;
      if (cal_load)
         base_nxt = smp_valid ? imp : prev;
      else if (smp_valid && !is_touch && !in_freeze) begin
         if (imp > base)      base_nxt = drift_sat;
         else if (imp < base) base_nxt = imp;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base  <= IMP_W'(MAXV);
         prev  <= IMP_W'(MAXV);
         touch <= 1'b0;
      end else begin
         base <= base_nxt;
         if (smp_valid) begin
            prev  <= imp;
            touch <= is_touch;
         end
      end
   end
endmodule

// File: rtl/tcal_sched.sv
module tcal_sched
   import touch_cal_pkg::*;
#(
   parameter int CFG_W          = 8,
   parameter int WAIT_SCALE     = 64,
   parameter int INTERVAL_SCALE = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             any_touch,
   input  logic             hold,
   input  logic [CFG_W-1:0] quiet_cfg,
   input  logic [CFG_W-1:0] repeat_cfg,
   input  logic             force_req,
   input  logic             cond_req,
   output logic             cal_now,
   output logic             force_pend,
   output logic             cond_pend,
   output logic             cal_done
);
   localparam int MAX_SCALE = (WAIT_SCALE > INTERVAL_SCALE) ? WAIT_SCALE : INTERVAL_SCALE;
   localparam int CW        = $clog2(((1 << CFG_W) - 1) * MAX_SCALE + 1);

   cal_phase_e    phase;
   logic [CW-1:0] cnt, tgt;
   logic          auto_fire, exec_f, exec_c;

   assign tgt = (phase == PH_REPEAT) ? CW'(repeat_cfg) * CW'(INTERVAL_SCALE)
                                     : CW'(quiet_cfg)  * CW'(WAIT_SCALE);
   assign auto_fire = !hold && !any_touch && tick &&
                      (({1'b0, cnt} + 1'b1) >= {1'b0, tgt});
   assign exec_f  = force_pend && hold;
   assign exec_c  = cond_pend && hold && !any_touch;
   assign cal_now = auto_fire || exec_f || exec_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= PH_QUIET;
      end else if (hold || any_touch) begin
         cnt   <= '0;
         phase <= PH_QUIET;
      end else if (tick) begin
         if (auto_fire) begin
            cnt   <= '0;
            phase <= PH_REPEAT;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_pend <= 1'b0;
         cond_pend  <= 1'b0;
         cal_done   <= 1'b0;
      end else begin
         force_pend <= hold && (force_pend ? 1'b0 : force_req);
         cond_pend  <= hold && (cond_pend ? !exec_c : cond_req);
         cal_done   <= cal_now;
      end
   end
endmodule

// File: rtl/touch_cal_tracker.sv
module touch_cal_tracker #(
   parameter int NCH            = 3,
   parameter int RAW_W          = 8,
   parameter int IMP_W          = 7,
   parameter int CFG_W          = 8,
   parameter int WAIT_SCALE     = 64,
   parameter int INTERVAL_SCALE = 50
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   smp_valid,
   input  logic [NCH*RAW_W-1:0]   smp_raw,
   input  logic [NCH*IMP_W-1:0]   tvr_cfg,
   input  logic [IMP_W-1:0]       evr_cfg,
   input  logic [CFG_W-1:0]       quiet_cfg,
   input  logic [CFG_W-1:0]       repeat_cfg,
   input  logic                   hold,
   input  logic                   force_req,
   input  logic                   cond_req,
   output logic [NCH-1:0]         touch,
   output logic [NCH*IMP_W-1:0]   base_out,
   output logic                   force_pend,
   output logic                   cond_pend,
   output logic                   cal_done
);
   if (IMP_W > RAW_W) begin : g_bad_width
      $error("IMP_W must not exceed RAW_W");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (WAIT_SCALE < 1 || INTERVAL_SCALE < 1) begin : g_bad_scale
      $error("scale factors must be positive");
   end

   logic cal_now;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      tcal_channel #(.RAW_W(RAW_W), .IMP_W(IMP_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .smp_valid (smp_valid),
         .raw       (smp_raw[i*RAW_W +: RAW_W]),
         .tvr       (tvr_cfg[i*IMP_W +: IMP_W]),
         .evr       (evr_cfg),
         .cal_load  (cal_now),
         .touch     (touch[i]),
         .base      (base_out[i*IMP_W +: IMP_W])
      );
   end

   tcal_sched #(
      .CFG_W(CFG_W), .WAIT_SCALE(WAIT_SCALE), .INTERVAL_SCALE(INTERVAL_SCALE)
   ) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .any_touch  (|touch),
      .hold       (hold),
      .quiet_cfg  (quiet_cfg),
      .repeat_cfg (repeat_cfg),
      .force_req  (force_req),
      .cond_req   (cond_req),
      .cal_now    (cal_now),
      .force_pend (force_pend),
      .cond_pend  (cond_pend),
      .cal_done   (cal_done)
   );
endmodule

// File: rtl/touch_cal_checker.sv
module touch_cal_checker #(
   parameter int NCH   = 3,
   parameter int IMP_W = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_valid,
   input logic                 hold,
   input logic [NCH-1:0]       touch,
   input logic [NCH*IMP_W-1:0] base_out,
   input logic                 force_pend,
   input logic                 cond_pend,
   input logic                 cal_done
);
   // Baselines move only on a sample or a calibration (R5, R6)
   assert_base_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> (cal_done || $stable(base_out)));

   // Verdicts change only after a sample (R2)
   assert_touch_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(touch));

   assert_force_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (force_pend && hold) |=> (cal_done && !force_pend));

   assert_cond_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_pend && hold && touch == '0) |=> (cal_done && !cond_pend));

   assert_cond_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_pend && hold && |touch) |=> cond_pend);

   assert_hold_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> (!force_pend && !cond_pend));

   assert_hold_no_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !force_pend && !cond_pend) |=> !cal_done);

   assert_touch_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|touch && !force_pend) |=> !cal_done);
endmodule

bind touch_cal_tracker touch_cal_checker #(.NCH(NCH), .IMP_W(IMP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .hold       (hold),
   .touch      (touch),
   .base_out   (base_out),
   .force_pend (force_pend),
   .cond_pend  (cond_pend),
   .cal_done   (cal_done)
);

// File: tb/tb_touch_cal_tracker.sv
`timescale 1ns/1ps
module tb_touch_cal_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        smp_valid = 1'b0;
   logic [23:0] smp_raw = '0;
   logic [20:0] tvr_cfg = {7'd10, 7'd8, 7'd8};
   logic [6:0]  evr_cfg = 7'd4;
   logic [7:0]  quiet_cfg = 8'd1;
   logic [7:0]  repeat_cfg = 8'd1;
   logic        hold = 1'b1;
   logic        force_req = 1'b0;
   logic        cond_req = 1'b0;
   logic [2:0]  touch;
   logic [20:0] base_out;
   logic        force_pend, cond_pend, cal_done;

   touch_cal_tracker dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .smp_valid(smp_valid),
      .smp_raw(smp_raw), .tvr_cfg(tvr_cfg), .evr_cfg(evr_cfg),
      .quiet_cfg(quiet_cfg), .repeat_cfg(repeat_cfg), .hold(hold),
      .force_req(force_req), .cond_req(cond_req), .touch(touch),
      .base_out(base_out), .force_pend(force_pend), .cond_pend(cond_pend),
      .cal_done(cal_done)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int eb[3] = '{127, 127, 127};
   int ep[3] = '{127, 127, 127};
   bit et[3] = '{0, 0, 0};
   logic [23:0] exp_q[$];
   string       tag_q[$];
   logic        v_d = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [20:0] pack_base();
      return {7'(eb[2]), 7'(eb[1]), 7'(eb[0])};
   endfunction

   function automatic int tvr_of(int ch);
      return (ch == 2) ? 10 : 8;
   endfunction

   function automatic void mdl(int ch, int imp, bit cal);
      int nb;
      bit t;
      t  = imp > eb[ch] + tvr_of(ch);
      nb = eb[ch];
      if (cal) nb = imp;
      else if (!t && !(imp > eb[ch] + 4)) begin
         if (imp > eb[ch]) begin
            nb = eb[ch] + imp - ep[ch];
            if (nb < 0) nb = 0;
            if (nb > 127) nb = 127;
         end else if (imp < eb[ch]) nb = imp;
      end
      et[ch] = t;
      eb[ch] = nb;
      ep[ch] = imp;
   endfunction

   function automatic void mdl_cal();
      for (int c = 0; c < 3; c++) eb[c] = ep[c];
   endfunction

   // driver: called at a falling edge; result is compared one cycle later
   task automatic send(input int i0, input int i1, input int i2, input string tag,
                       input bit cal = 1'b0);
      smp_raw   = {8'h80 | 8'(127 - i2), 8'(127 - i1), 8'(127 - i0)};
      smp_valid = 1'b1;
      mdl(0, i0, cal);
      mdl(1, i1, cal);
      mdl(2, i2, cal);
      exp_q.push_back({{et[2], et[1], et[0]}, pack_base()});
      tag_q.push_back(tag);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   always @(posedge clk) v_d <= smp_valid;

   // monitor
   always @(negedge clk) begin
      if (v_d && exp_q.size() > 0) begin
         logic [23:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(touch == e[23:21], {t, " touch"}, touch, e[23:21]);
         chk(base_out == e[20:0], {t, " baseline"}, base_out, e[20:0]);
      end
   end

   task automatic do_tick(output bit fired);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      fired = cal_done;
      if (fired) mdl_cal();
   endtask

   task automatic ticks(input int n, output int fires);
      bit f;
      fires = 0;
      for (int k = 0; k < n; k++) begin
         do_tick(f);
         if (f) fires++;
      end
   endtask

   initial begin
      #(20 * 200000);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int fires;
      bit f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(base_out == {3{7'd127}}, "R12 baseline", base_out, {3{7'd127}});
      chk(touch == 3'b000, "R12 touch", touch, 0);
      chk({cal_done, force_pend, cond_pend} == 3'b000, "R12 flags",
          {cal_done, force_pend, cond_pend}, 0);

      // R8: ticks under hold never calibrate
      ticks(100, fires);
      chk(fires == 0, "R8 hold ticks", fires, 0);

      // tracking rules
      send(100, 60, 90, "R1 R5 snap");
      send(102, 60, 95, "R4 R5 R3 mix");
      send(105, 59, 93, "R4 drift");
      send(111, 70, 80, "R3 R2 freeze/touch");
      send(114,  5, 80, "R2 R5 touch/snap");
      send(107, 20, 81, "R4 R2 drift/touch");
      send( 98,  7, 81, "R4 clamp");
      @(negedge clk);

      // R9 force request while a channel is touched
      send(120, 7, 81, "R2 pre-force");
      force_req = 1'b1;
      @(negedge clk);
      force_req = 1'b0;
      chk(force_pend == 1'b1, "R9 pending", force_pend, 1);
      @(negedge clk);
      mdl_cal();
      chk(cal_done == 1'b1, "R9 done", cal_done, 1);
      chk(force_pend == 1'b0, "R9 cleared", force_pend, 0);
      chk(base_out == pack_base(), "R9 baseline", base_out, pack_base());

      // R10 conditional request waits for touch to clear
      send(100, 30, 81, "R10 touch");
      cond_req = 1'b1;
      @(negedge clk);
      cond_req = 1'b0;
      fires = 0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (cal_done || !cond_pend) fires++;
      end
      chk(fires == 0, "R10 waits", fires, 0);
      send(100, 9, 81, "R10 release");
      @(negedge clk);
      mdl_cal();
      chk(cal_done == 1'b1, "R10 done", cal_done, 1);
      chk(cond_pend == 1'b0, "R10 cleared", cond_pend, 0);
      chk(base_out == pack_base(), "R10 baseline", base_out, pack_base());

      // R11 calibration collides with a sample
      force_req = 1'b1;
      @(negedge clk);
      force_req = 1'b0;
      send(110, 30, 60, "R11 collide", 1'b1);
      chk(cal_done == 1'b1, "R11 done", cal_done, 1);

      // R8 request ignored without hold
      hold = 1'b0;
      @(negedge clk);
      force_req = 1'b1;
      @(negedge clk);
      force_req = 1'b0;
      chk(force_pend == 1'b0, "R8 ignored", force_pend, 0);
      @(negedge clk);
      chk(cal_done == 1'b0, "R8 no cal", cal_done, 0);
      chk(base_out == pack_base(), "R8 baseline", base_out, pack_base());

      // R6 quiet period then automatic calibration
      send(116, 36, 60, "R3 pre-auto");
      ticks(63, fires);
      chk(fires == 0, "R6 early", fires, 0);
      do_tick(f);
      chk(f == 1'b1, "R6 fire", f, 1);
      chk(base_out == pack_base(), "R6 baseline", base_out, pack_base());

      // R7 repeat interval, touch restarts the quiet period
      ticks(49, fires);
      chk(fires == 0, "R7 early", fires, 0);
      do_tick(f);
      chk(f == 1'b1, "R7 repeat", f, 1);
      ticks(20, fires);
      send(127, 36, 60, "R7 touch");
      ticks(5, fires);
      chk(fires == 0, "R7 touched", fires, 0);
      send(116, 36, 60, "R7 release");
      ticks(63, fires);
      chk(fires == 0, "R7 restart", fires, 0);
      do_tick(f);
      chk(f == 1'b1, "R7 quiet fire", f, 1);

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule